// File: doc/BRIEF.md
# CAS-before-RAS Refresh Generator

This block keeps asynchronous DRAM alive by scheduling and driving column-first refresh cycles. A slow reference tick, synchronised to the core clock and about 14.318 MHz in rate, drives an interval counter. Every 223 ticks (close to 15.6 µs) the counter reloads and the block asks the memory arbiter for the bus.

Once the arbiter grants the request, the block pulls all column strobes low together for one lead cycle. It then walks the row strobes in ascending bank order. Each row strobe is held low for a parameterised number of clocks and is released for one clock before the next bank starts. A done pulse marks the release of the last row strobe, and the column strobes return high on the following clock.

Expiries that arrive while a request waits are remembered, up to two outstanding refreshes. The arbiter can therefore catch up with back-to-back cycles after a long hold-off.

Top module: `cbr_refresh_gen`

## Requirements
- R1: During and directly after reset, `rfsh_req` and `rfsh_done` are 0 and every bit of `cas_n` and `ras_n` is 1.
- R2: The interval counter counts `ref_tick` pulses and reloads on the TERM_TICKS-th one (default 223). An expiry adds one outstanding refresh. `rfsh_req` is 1 in the clock after the edge that sampled the expiring tick.
- R3: `rfsh_req` stays 1 until a grant is accepted. A grant seen while `rfsh_req` is 0 starts nothing, and the strobes stay high.
- R4: At most two refreshes are outstanding. A third expiry without a grant in between is lost, so holding the grant afterwards yields exactly two cycles.
- R5: If an expiry and an accepted grant fall in the same clock, both count: one outstanding refresh is consumed and one is added.
- R6: A cycle starts in the clock after the accepted grant. All `cas_n` bits go low together, and they stay low for one clock before any `ras_n` bit falls.
- R7: `ras_n` bits fall one at a time in order bit 0 to bit 5. Each bit is low for STROBE_CLKS clocks (default 3) and is followed by one clock with all `ras_n` high.
- R8: `rfsh_done` is a one-clock pulse in the first clock after `ras_n[5]` returns high. In the next clock all `cas_n` bits return high, so a whole cycle lasts 1 + 6*(STROBE_CLKS+1) clocks.
- R9: `rfsh_req` is 0 while a cycle is in progress, and grants during a cycle are ignored. The interval counter keeps counting throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock pulse per reference-clock period, already synchronised |
| rfsh_gnt | input | 1 | Grant from the memory arbiter |
| rfsh_req | output | 1 | Refresh request to the arbiter |
| rfsh_done | output | 1 | Pulse when the last row strobe is released |
| cas_n | output | 8 | Column strobes, active low |
| ras_n | output | 6 | Row strobes, active low |

## Verification
An interval expiry can land in the same clock as an accepted grant. This makes the outstanding counter decrement and increment at once, which matters most when it sits at its limit. The bench provokes this by driving the reference ticks by hand, so that the expiring tick and the grant are driven together in one cycle. The behavioural model predicts the request level after that cycle, and the bench checks that the request comes back once the cycle ends and that the follow-up refresh completes.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_LEAD   = 2'd1,
      SEQ_STROBE = 2'd2,
      SEQ_GAP    = 2'd3
   } seq_state_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int TERM_TICKS = 223
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic expire
);
   localparam int CW = $clog2(TERM_TICKS);
   localparam logic [CW-1:0] LAST = CW'(TERM_TICKS - 1);

   logic [CW-1:0] cnt;

   assign expire = tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (expire) cnt <= '0;
      else if (tick)   cnt <= cnt + CW'(1);
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/rfsh_pending_tracker.sv
module rfsh_pending_tracker #(
   parameter int PEND_MAX = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic gnt,
   input  logic seq_idle,
   output logic req,
   output logic start
);
   localparam int PW = $clog2(PEND_MAX + 1);
   localparam logic [PW-1:0] PMAX = PW'(PEND_MAX);

   logic [PW-1:0] pend, pend_dec, pend_nx;

   assign req   = (pend != '0) && seq_idle;
   assign start = req && gnt;

   always_comb begin
      pend_dec = pend - PW'(start);
      pend_nx  = (expire && (pend_dec < PMAX)) ? pend_dec + PW'(1) : pend_dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nx;
   end

   // R4
   pend_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PMAX);

   // R5
   pend_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && expire) |=> (pend == $past(pend)));
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
   import refresh_pkg::*;
#(
   parameter int NUM_CAS     = 8,
   parameter int NUM_RAS     = 6,
   parameter int STROBE_CLKS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               idle,
   output logic               done,
   output logic [NUM_CAS-1:0] cas_n,
   output logic [NUM_RAS-1:0] ras_n
);
   localparam int BW = $clog2(NUM_RAS);
   localparam logic [BW-1:0] BLAST = BW'(NUM_RAS - 1);

   seq_state_t    state;
   logic [BW-1:0] bank;
   logic          wlast;

   generate
      if (STROBE_CLKS == 1) begin : g_single
         assign wlast = 1'b1;
      end else begin : g_count
         localparam int WW = $clog2(STROBE_CLKS);
         localparam logic [WW-1:0] WMAX = WW'(STROBE_CLKS - 1);
         logic [WW-1:0] wcnt;
         assign wlast = (wcnt == WMAX);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    wcnt <= '0;
            else if (state != SEQ_STROBE)  wcnt <= '0;
            else if (wlast)                wcnt <= '0;
            else                           wcnt <= wcnt + WW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         bank  <= '0;
      end else begin
         case (state)
            SEQ_IDLE:   if (start) state <= SEQ_LEAD;
            SEQ_LEAD: begin
               state <= SEQ_STROBE;
               bank  <= '0;
            end
            SEQ_STROBE: if (wlast) state <= SEQ_GAP;
            SEQ_GAP: begin
               if (bank == BLAST) state <= SEQ_IDLE;
               else begin
                  bank  <= bank + BW'(1);
                  state <= SEQ_STROBE;
               end
            end
            default:    state <= SEQ_IDLE;
         endcase
      end
   end

   assign idle  = (state == SEQ_IDLE);
   assign done  = (state == SEQ_GAP) && (bank == BLAST);
   assign cas_n = idle ? '1 : '0;

   for (genvar i = 0; i < NUM_RAS; i++) begin : g_ras
      assign ras_n[i] = !((state == SEQ_STROBE) && (bank == BW'(i)));
   end

   // R6
   cas_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n == '0) || (cas_n == '1));
   // R6
   cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n[0]) |-> (ras_n == '1));
   // R7
   ras_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ras_n));
   // R7
   ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n != '1) |-> (cas_n == '0));
   // R8
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((ras_n == '1) && (cas_n == '0)) ##1 (cas_n == '1));
   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> idle);
endmodule

// File: rtl/cbr_refresh_gen.sv
module cbr_refresh_gen #(
   parameter int TERM_TICKS  = 223,
   parameter int PEND_MAX    = 2,
   parameter int NUM_CAS     = 8,
   parameter int NUM_RAS     = 6,
   parameter int STROBE_CLKS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic               rfsh_gnt,
   output logic               rfsh_req,
   output logic               rfsh_done,
   output logic [NUM_CAS-1:0] cas_n,
   output logic [NUM_RAS-1:0] ras_n
);
   generate
      if (TERM_TICKS < 2)  begin : g_bad_term  $error("TERM_TICKS must be at least 2"); end
      if (PEND_MAX < 1)    begin : g_bad_pend  $error("PEND_MAX must be at least 1"); end
      if (NUM_CAS < 1)     begin : g_bad_cas   $error("NUM_CAS must be at least 1"); end
      if (NUM_RAS < 2)     begin : g_bad_ras   $error("NUM_RAS must be at least 2"); end
      if (STROBE_CLKS < 1) begin : g_bad_width $error("STROBE_CLKS must be at least 1"); end
   endgenerate

   logic expire, start, seq_idle;

   rfsh_interval_timer #(.TERM_TICKS(TERM_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick), .expire(expire)
   );

   rfsh_pending_tracker #(.PEND_MAX(PEND_MAX)) u_track (
      .clk(clk), .rst_n(rst_n), .expire(expire), .gnt(rfsh_gnt),
      .seq_idle(seq_idle), .req(rfsh_req), .start(start)
   );

   rfsh_strobe_seq #(
      .NUM_CAS(NUM_CAS), .NUM_RAS(NUM_RAS), .STROBE_CLKS(STROBE_CLKS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .idle(seq_idle),
      .done(rfsh_done), .cas_n(cas_n), .ras_n(ras_n)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rfsh_req && !rfsh_done && (cas_n == '1) && (ras_n == '1)));
endmodule

// File: tb/test_cbr_refresh_gen.sv
module test_cbr_refresh_gen;
   localparam int TERM  = 223;
   localparam int W     = 3;
   localparam int NC    = 8;
   localparam int NR    = 6;
   localparam int TOTAL = 1 + NR * (W + 1);

   logic clk = 0, rst_n = 0, tick = 0, gnt = 0;
   logic rfsh_req, rfsh_done;
   logic [NC-1:0] cas_n;
   logic [NR-1:0] ras_n;

   int errors = 0, checks = 0;
   int m_tick = 0, m_pend = 0, m_pos = -1;
   int tick_seen = 0, done_seen = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cbr_refresh_gen #(.TERM_TICKS(TERM), .STROBE_CLKS(W)) i_cbr_refresh_gen (
      .clk(clk), .rst_n(rst_n), .ref_tick(tick), .rfsh_gnt(gnt),
      .rfsh_req(rfsh_req), .rfsh_done(rfsh_done), .cas_n(cas_n), .ras_n(ras_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // behavioural reference: counts, positions and arithmetic only
   always @(posedge clk) begin
      if (!rst_n) begin
         m_tick = 0; m_pend = 0; m_pos = -1;
      end else begin
         bit st, ex;
         int p;
         st = gnt && (m_pend > 0) && (m_pos < 0);
         ex = tick && (m_tick == TERM - 1);
         if (tick) begin
            tick_seen++;
            m_tick = ex ? 0 : m_tick + 1;
         end
         p = m_pend - (st ? 1 : 0);
         if (ex && p < 2) p++;
         m_pend = p;
         if (st) m_pos = 0;
         else if (m_pos >= 0) begin
            m_pos++;
            if (m_pos == TOTAL) m_pos = -1;
         end
      end
   end

   // every-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [NC-1:0] e_cas;
         logic [NR-1:0] e_ras;
         bit e_done, e_req;
         e_cas = (m_pos >= 0) ? '0 : '1;
         e_ras = '1;
         e_done = 0;
         if (m_pos >= 1) begin
            int q, b, r;
            q = m_pos - 1; b = q / (W + 1); r = q % (W + 1);
            if (r < W) e_ras[b] = 1'b0;
            e_done = (r == W) && (b == NR - 1);
         end
         e_req = (m_pend > 0) && (m_pos < 0);
         chk(cas_n == e_cas, "R6 cas_n", cas_n, e_cas);
         chk(ras_n == e_ras, "R7 ras_n", ras_n, e_ras);
         chk(rfsh_done == e_done, "R8 rfsh_done", rfsh_done, e_done);
         chk(rfsh_req == e_req, "R2/R9 rfsh_req", rfsh_req, e_req);
         if (rfsh_done) done_seen++;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      int d0;
      bit ok;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!rfsh_req && !rfsh_done && cas_n == '1 && ras_n == '1, "R1 reset outputs",
          {rfsh_req, rfsh_done, cas_n, ras_n}, {2'b00, 8'hFF, 6'h3F});
      rst_n = 1;
      // R3: grant without request does nothing
      gnt = 1;
      repeat (8) @(negedge clk);
      chk(cas_n == '1 && ras_n == '1, "R3 grant without request", {cas_n, ras_n}, {8'hFF, 6'h3F});
      gnt = 0;
      // R2: first expiry after TERM ticks
      ok = 0;
      for (int c = 0; c < 4 * TERM; c++) begin
         @(negedge clk);
         if (rfsh_req) begin ok = 1; break; end
         tick = (c % 3 == 0);
      end
      tick = 0;
      chk(ok && tick_seen == TERM, "R2 ticks to first request", tick_seen, TERM);
      // R3: request holds without grant
      repeat (20) @(negedge clk);
      chk(rfsh_req == 1, "R3 request held", rfsh_req, 1);
      gnt = 1;
      repeat (5) @(negedge clk);
      chk(rfsh_req == 0 && cas_n == '0, "R9 busy hides request", {rfsh_req, cas_n}, 9'h000);
      gnt = 0;
      repeat (TOTAL) @(negedge clk);
      chk(rfsh_req == 0 && cas_n == '1, "R8 cycle finished", {rfsh_req, cas_n}, 9'h0FF);
      // R4: three expiries without grant, then exactly two cycles
      for (int c = 0; c < 3 * TERM * 3 + 30; c++) begin
         @(negedge clk);
         tick = (c % 3 == 0);
      end
      @(negedge clk);
      tick = 0;
      chk(m_pend == 2 && rfsh_req == 1, "R4 request pending after overflow", rfsh_req, 1);
      d0 = done_seen;
      gnt = 1;
      repeat (3 * TOTAL + 10) @(negedge clk);
      gnt = 0;
      chk(done_seen - d0 == 2, "R4 saturated backlog count", done_seen - d0, 2);
      chk(rfsh_req == 0, "R4 backlog drained", rfsh_req, 0);
      // R5: expiry and accepted grant in the same clock
      while (m_pend == 0) begin @(negedge clk); tick = !tick; end
      @(negedge clk); tick = 0;
      while (m_tick != TERM - 1) begin @(negedge clk); tick = !tick; end
      @(negedge clk);
      if (m_tick != TERM - 1) begin tick = 1; @(negedge clk); end
      tick = 1; gnt = 1;
      @(negedge clk);
      tick = 0; gnt = 0;
      repeat (TOTAL + 2) @(negedge clk);
      chk(rfsh_req == 1, "R5 expiry kept across grant", rfsh_req, 1);
      d0 = done_seen;
      gnt = 1;
      repeat (TOTAL + 4) @(negedge clk);
      gnt = 0;
      chk(done_seen - d0 == 1 && rfsh_req == 0, "R5 follow-up refresh", done_seen - d0, 1);
      repeat (4) @(negedge clk);
      summary();
   end
endmodule